// File: doc/BRIEF.md
# Reset Cause Status Register

This block keeps a small set of sticky status flags that tell firmware what caused the most recent restart or wake-up. The flags are active-low and only change when an event happens. Each event changes only some of them, so the combination left in the register tells the events apart. The block takes one strobe for each event: external pin while running, external pin during sleep, software reset, stack full, stack underflow, watchdog timeout while running, watchdog timeout during sleep, brown-out, and interrupt wake-up. Power-on is the asynchronous active-low reset. The block also takes a sleep-entry strobe, a watchdog-clear strobe and a software write port.

For every reset or wake event, the block also produces the address where execution continues, together with a one-cycle load strobe. A reset restarts at address zero. A wake-up resumes at the current program counter plus 2, or at an interrupt vector when global interrupts are enabled. Only one event is taken per cycle, chosen by a fixed priority. Status and address are registered, so they appear one clock after the event.

Status bit layout: bit0 `swr_n` (software reset, active-low), bit1 `wdt_n` (watchdog timeout, active-low), bit2 `pwd_n` (power-down, active-low), bit3 `por_n`, bit4 `bor_n`, bit5 stack-full, bit6 stack-underflow, bit7 unused and always 0.

Top module: `rst_cause_reg`

## Requirements
- R1: While `pwr_on_rst_n` is low, `status_o` is 8'h07 (swr_n=1, wdt_n=1, pwd_n=1, por_n=0, bor_n=0, both stack flags 0), `pc_load_o` is 0 and `pc_next_o` is 0.
- R2: A brown-out sets swr_n, wdt_n, pwd_n and por_n to 1 and clears bor_n to 0. It leaves the stack flags unchanged and loads address 0.
- R3: A software reset clears swr_n to 0 and leaves all other bits unchanged. It loads address 0.
- R4: An external pin reset while running, a stack-full reset and a stack-underflow reset leave bits 0 to 4 unchanged and load address 0. A stack-full reset sets bit5 and a stack-underflow reset sets bit6; no other event sets either bit.
- R5: An external pin reset during sleep sets wdt_n=1 and pwd_n=0, leaves the other bits unchanged and loads address 0.
- R6: A watchdog timeout while running sets wdt_n=0 and pwd_n=1 and loads address 0.
- R7: A watchdog timeout during sleep sets wdt_n=0 and pwd_n=0 and loads `pc_i`+2.
- R8: An interrupt wake-up sets wdt_n=1 and pwd_n=0. With both `gie_hi_i` and `gie_lo_i` low it loads `pc_i`+2. Otherwise it loads 'h08 when `irq_hi_i` is 1 and 'h18 when `irq_hi_i` is 0.
- R9: A sleep-entry strobe sets wdt_n=1 and pwd_n=0. A watchdog-clear strobe sets wdt_n=1 and pwd_n=1. Neither strobe raises `pc_load_o` or changes `pc_next_o`.
- R10: A software write sets swr_n, por_n and bor_n (bits 0, 3, 4) to 1 where the data bit is 1. It clears the stack flags (bits 5, 6) where the data bit is 1. Data 0 changes nothing, and data on bits 1, 2 and 7 is ignored.
- R11: Only one event is taken per cycle, in this order from highest: brown-out, pin reset in sleep, pin reset running, watchdog running, software reset, stack full, stack underflow, watchdog in sleep, interrupt wake, sleep entry, watchdog clear, software write.
- R12: Status, `pc_load_o` and `pc_next_o` change on the clock edge that samples the event. `pc_load_o` is high only for the cycle after a reset or wake event, and bit7 always reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| pwr_on_rst_n | input | 1 | Power-on reset, asynchronous, active low |
| ext_run_i | input | 1 | External pin reset while running |
| ext_sleep_i | input | 1 | External pin reset during sleep |
| swrst_i | input | 1 | Software reset instruction |
| stk_full_i | input | 1 | Stack-full reset |
| stk_unf_i | input | 1 | Stack-underflow reset |
| wdt_run_i | input | 1 | Watchdog timeout while running |
| wdt_sleep_i | input | 1 | Watchdog timeout during sleep |
| brownout_i | input | 1 | Brown-out detected |
| irq_wake_i | input | 1 | Interrupt wake-up from sleep |
| sleep_i | input | 1 | Sleep instruction executed |
| wdt_clr_i | input | 1 | Watchdog cleared |
| gie_hi_i | input | 1 | High-priority global interrupt enable |
| gie_lo_i | input | 1 | Low-priority global interrupt enable |
| irq_hi_i | input | 1 | Waking interrupt is high priority |
| pc_i | input | PCW | Current program counter |
| wr_en_i | input | 1 | Software write strobe |
| wr_data_i | input | 8 | Software write data |
| status_o | output | 8 | Flag bits |
| pc_load_o | output | 1 | Restart address valid, one cycle |
| pc_next_o | output | PCW | Restart address |

## Verification
The assertions assume that every event input is a one-cycle strobe sampled on the rising clock edge. They also assume that `pc_i` is settled at the edge where a watchdog wake is taken. Several events may arrive together, and the properties account for the priority before they predict a flag pattern. The stimulus changes inputs only at the falling edge and holds `pc_i` constant around wake events. Deliberate collisions exercise the priority order.

// File: rtl/rst_cause_reg.sv
module rst_cause_reg #(
  parameter int PCW = 21,
  parameter logic [PCW-1:0] VEC_HI = 'h08,
  parameter logic [PCW-1:0] VEC_LO = 'h18
) (
  input  logic           clk,
  input  logic           pwr_on_rst_n,
  input  logic           ext_run_i,
  input  logic           ext_sleep_i,
  input  logic           swrst_i,
  input  logic           stk_full_i,
  input  logic           stk_unf_i,
  input  logic           wdt_run_i,
  input  logic           wdt_sleep_i,
  input  logic           brownout_i,
  input  logic           irq_wake_i,
  input  logic           sleep_i,
  input  logic           wdt_clr_i,
  input  logic           gie_hi_i,
  input  logic           gie_lo_i,
  input  logic           irq_hi_i,
  input  logic [PCW-1:0] pc_i,
  input  logic           wr_en_i,
  input  logic [7:0]     wr_data_i,
  output logic [7:0]     status_o,
  output logic           pc_load_o,
  output logic [PCW-1:0] pc_next_o
);
  logic swr_q, wdt_q, pwd_q, por_q, bor_q, full_q, unf_q;
  logic swr_d, wdt_d, pwd_d, por_d, bor_d, full_d, unf_d;
  logic ld_q, ld_d;
  logic [PCW-1:0] pc_q, pc_d;

  wire [PCW-1:0] pc_inc = pc_i + PCW'(2);
  wire           vec_en = gie_hi_i | gie_lo_i;
  wire [PCW-1:0] vec    = irq_hi_i ? VEC_HI : VEC_LO;

  always_comb begin
    swr_d = swr_q; wdt_d = wdt_q; pwd_d = pwd_q;
    por_d = por_q; bor_d = bor_q; full_d = full_q; unf_d = unf_q;
    ld_d  = 1'b0;
    pc_d  = pc_q;
    if (brownout_i) begin
      swr_d = 1'b1; wdt_d = 1'b1; pwd_d = 1'b1; por_d = 1'b1; bor_d = 1'b0;
      ld_d = 1'b1; pc_d = '0;
    end else if (ext_sleep_i) begin
      wdt_d = 1'b1; pwd_d = 1'b0;
      ld_d = 1'b1; pc_d = '0;
    end else if (ext_run_i) begin
      ld_d = 1'b1; pc_d = '0;
    end else if (wdt_run_i) begin
      wdt_d = 1'b0; pwd_d = 1'b1;
      ld_d = 1'b1; pc_d = '0;
    end else if (swrst_i) begin
      swr_d = 1'b0;
      ld_d = 1'b1; pc_d = '0;
    end else if (stk_full_i) begin
      full_d = 1'b1;
      ld_d = 1'b1; pc_d = '0;
    end else if (stk_unf_i) begin
      unf_d = 1'b1;
      ld_d = 1'b1; pc_d = '0;
    end else if (wdt_sleep_i) begin
      wdt_d = 1'b0; pwd_d = 1'b0;
      ld_d = 1'b1; pc_d = pc_inc;
    end else if (irq_wake_i) begin
      wdt_d = 1'b1; pwd_d = 1'b0;
      ld_d = 1'b1; pc_d = vec_en ? vec : pc_inc;
    end else if (sleep_i) begin
      wdt_d = 1'b1; pwd_d = 1'b0;
    end else if (wdt_clr_i) begin
      wdt_d = 1'b1; pwd_d = 1'b1;
    end else if (wr_en_i) begin
      swr_d  = swr_q  | wr_data_i[0];
      por_d  = por_q  | wr_data_i[3];
      bor_d  = bor_q  | wr_data_i[4];
      full_d = full_q & ~wr_data_i[5];
      unf_d  = unf_q  & ~wr_data_i[6];
    end
  end

  always_ff @(posedge clk or negedge pwr_on_rst_n) begin
    if (!pwr_on_rst_n) begin
      swr_q <= 1'b1; wdt_q <= 1'b1; pwd_q <= 1'b1;
      por_q <= 1'b0; bor_q <= 1'b0; full_q <= 1'b0; unf_q <= 1'b0;
      ld_q  <= 1'b0;
      pc_q  <= '0;
    end else begin
      swr_q <= swr_d; wdt_q <= wdt_d; pwd_q <= pwd_d;
      por_q <= por_d; bor_q <= bor_d; full_q <= full_d; unf_q <= unf_d;
      ld_q  <= ld_d;
      pc_q  <= pc_d;
    end
  end

  assign status_o  = {1'b0, unf_q, full_q, bor_q, por_q, pwd_q, wdt_q, swr_q};
  assign pc_load_o = ld_q;
  assign pc_next_o = pc_q;
endmodule

module rst_cause_reg_chk #(
  parameter int PCW = 21
) (
  input logic           clk,
  input logic           pwr_on_rst_n,
  input logic           ext_run_i,
  input logic           ext_sleep_i,
  input logic           swrst_i,
  input logic           stk_full_i,
  input logic           stk_unf_i,
  input logic           wdt_run_i,
  input logic           wdt_sleep_i,
  input logic           brownout_i,
  input logic           irq_wake_i,
  input logic           sleep_i,
  input logic           wdt_clr_i,
  input logic [PCW-1:0] pc_i,
  input logic           wr_en_i,
  input logic [7:0]     status_o,
  input logic           pc_load_o,
  input logic [PCW-1:0] pc_next_o
);
  wire any_rst  = brownout_i | ext_run_i | ext_sleep_i | swrst_i | stk_full_i | stk_unf_i | wdt_run_i;
  wire any_wake = wdt_sleep_i | irq_wake_i;

  p_brownout_r2: assert property (@(posedge clk) disable iff (!pwr_on_rst_n)
    brownout_i |=> (status_o[4:0] == 5'b01111) && pc_load_o && (pc_next_o == '0));

  p_swrst_only_r3: assert property (@(posedge clk) disable iff (!pwr_on_rst_n)
    (swrst_i && !brownout_i && !ext_sleep_i && !ext_run_i && !wdt_run_i)
    |=> !status_o[0] && (status_o[7:1] == $past(status_o[7:1])));

  p_wdt_sleep_pc_r7: assert property (@(posedge clk) disable iff (!pwr_on_rst_n)
    (wdt_sleep_i && !any_rst) |=> (status_o[2:1] == 2'b00) && (pc_next_o == $past(pc_i) + PCW'(2)));

  p_ro_bits_r10: assert property (@(posedge clk) disable iff (!pwr_on_rst_n)
    (wr_en_i && !any_rst && !any_wake && !sleep_i && !wdt_clr_i) |=> $stable(status_o[2:1]) && !pc_load_o);

  p_load_cause_r12: assert property (@(posedge clk) disable iff (!pwr_on_rst_n)
    (!any_rst && !any_wake) |=> !pc_load_o);

  p_unused_zero_r12: assert property (@(posedge clk) disable iff (!pwr_on_rst_n)
    !status_o[7]);
endmodule

bind rst_cause_reg rst_cause_reg_chk #(.PCW(PCW)) u_chk (
  .clk(clk), .pwr_on_rst_n(pwr_on_rst_n), .ext_run_i(ext_run_i), .ext_sleep_i(ext_sleep_i),
  .swrst_i(swrst_i), .stk_full_i(stk_full_i), .stk_unf_i(stk_unf_i), .wdt_run_i(wdt_run_i),
  .wdt_sleep_i(wdt_sleep_i), .brownout_i(brownout_i), .irq_wake_i(irq_wake_i),
  .sleep_i(sleep_i), .wdt_clr_i(wdt_clr_i), .pc_i(pc_i), .wr_en_i(wr_en_i),
  .status_o(status_o), .pc_load_o(pc_load_o), .pc_next_o(pc_next_o)
);

// File: tb/rst_cause_reg_bench.sv
module rst_cause_reg_bench;
  localparam int PCW = 21;
  logic clk = 1'b0;
  logic pwr_on_rst_n = 1'b0;
  logic ext_run_i, ext_sleep_i, swrst_i, stk_full_i, stk_unf_i, wdt_run_i, wdt_sleep_i;
  logic brownout_i, irq_wake_i, sleep_i, wdt_clr_i, gie_hi_i, gie_lo_i, irq_hi_i, wr_en_i;
  logic [PCW-1:0] pc_i;
  logic [7:0] wr_data_i;
  logic [7:0] status_o;
  logic pc_load_o;
  logic [PCW-1:0] pc_next_o;

  int total = 0;
  int bad = 0;

  typedef struct {
    logic [7:0]     st;
    logic           ld;
    logic [PCW-1:0] pc;
    string          tag;
  } exp_t;
  exp_t q[$];

  always #10 clk = ~clk;

  rst_cause_reg #(.PCW(PCW)) u_rst_cause_reg (.*);

  task automatic clear_in();
    ext_run_i = 0; ext_sleep_i = 0; swrst_i = 0; stk_full_i = 0; stk_unf_i = 0;
    wdt_run_i = 0; wdt_sleep_i = 0; brownout_i = 0; irq_wake_i = 0; sleep_i = 0;
    wdt_clr_i = 0; gie_hi_i = 0; gie_lo_i = 0; irq_hi_i = 0; wr_en_i = 0; wr_data_i = 0;
  endtask

  task automatic push(input logic [7:0] st, input logic ld, input logic [PCW-1:0] pc, input string tag);
    exp_t e;
    e.st = st; e.ld = ld; e.pc = pc; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic check(input string tag, input logic [7:0] st, input logic ld, input logic [PCW-1:0] pc);
    total++;
    if (status_o !== st || pc_load_o !== ld || pc_next_o !== pc) begin
      bad++;
      $display("FAIL %s: got st=%h ld=%b pc=%h, exp st=%h ld=%b pc=%h",
               tag, status_o, pc_load_o, pc_next_o, st, ld, pc);
    end
  endtask

  always @(posedge clk) begin
    #5;
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      check(e.tag, e.st, e.ld, e.pc);
    end
  end

  task automatic nstep();
    @(negedge clk);
    clear_in();
  endtask

  initial begin
    clear_in();
    pc_i = 21'h01234;
    #15;
    check("R1 reset", 8'h07, 1'b0, '0);
    @(negedge clk); pwr_on_rst_n = 1'b1;
    nstep(); push(8'h07, 0, '0, "R12 idle");
    nstep(); wr_en_i = 1; wr_data_i = 8'h18; push(8'h1F, 0, '0, "R10 set por bor");
    nstep(); swrst_i = 1; push(8'h1E, 1, '0, "R3 swrst");
    nstep(); wr_en_i = 1; wr_data_i = 8'h01; push(8'h1F, 0, '0, "R10 set swr");
    nstep(); wdt_run_i = 1; push(8'h1D, 1, '0, "R6 wdt run");
    nstep(); wr_en_i = 1; wr_data_i = 8'h86; push(8'h1D, 0, '0, "R10 ro bits");
    nstep(); wdt_clr_i = 1; push(8'h1F, 0, '0, "R9 wdt clear");
    nstep(); sleep_i = 1; push(8'h1B, 0, '0, "R9 sleep");
    nstep(); wdt_sleep_i = 1; push(8'h19, 1, 21'h01236, "R7 wdt sleep");
    nstep(); ext_sleep_i = 1; push(8'h1B, 1, '0, "R5 pin sleep");
    nstep(); irq_wake_i = 1; push(8'h1B, 1, 21'h01236, "R8 wake no vector");
    nstep(); ext_run_i = 1; push(8'h1B, 1, '0, "R4 pin run");
    nstep(); irq_wake_i = 1; gie_hi_i = 1; irq_hi_i = 1; push(8'h1B, 1, 21'h00008, "R8 hi vector");
    nstep(); irq_wake_i = 1; gie_lo_i = 1; push(8'h1B, 1, 21'h00018, "R8 lo vector");
    nstep(); stk_full_i = 1; push(8'h3B, 1, '0, "R4 stack full");
    nstep(); stk_unf_i = 1; push(8'h7B, 1, '0, "R4 stack underflow");
    nstep(); wr_en_i = 1; wr_data_i = 8'h20; push(8'h5B, 0, '0, "R10 clear full");
    nstep(); wr_en_i = 1; wr_data_i = 8'h40; push(8'h1B, 0, '0, "R10 clear unf");
    nstep(); brownout_i = 1; swrst_i = 1; wdt_sleep_i = 1; push(8'h0F, 1, '0, "R2 R11 brownout wins");
    nstep(); swrst_i = 1; irq_wake_i = 1; push(8'h0E, 1, '0, "R11 reset over wake");
    nstep(); sleep_i = 1; wr_en_i = 1; wr_data_i = 8'h01; push(8'h0A, 0, '0, "R11 sleep over write");
    nstep(); wdt_sleep_i = 1; pc_i = 21'h1FFFFF; push(8'h08, 1, 21'h000001, "R7 pc wrap");
    nstep();
    @(negedge clk);
    pwr_on_rst_n = 1'b0;
    #5;
    check("R1 reset again", 8'h07, 1'b0, '0);
    @(negedge clk); pwr_on_rst_n = 1'b1;
    nstep(); push(8'h07, 0, '0, "R1 after reset");
    nstep();
    @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: got timeout, exp completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule